// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This block is the multi-cycle arithmetic engine of a pipelined 32-bit integer core. It computes signed and unsigned 32x32 products to a full 64-bit result. It also computes signed and unsigned 32-bit quotients together with their remainders. An operation begins on a single-cycle start pulse that carries a two-bit operation code and two operands. From the following cycle, `busy_o` stays high for the whole run, and the core uses it to freeze its pipeline.

Signed products use radix-2 Booth recoding. Unsigned products use plain shift-and-add. Both take one iteration per cycle for 32 cycles. Division runs 32 restoring iterations on operand magnitudes and then spends one more cycle on sign correction, for 33 cycles in all. When the run ends, a one-cycle `done_o` pulse marks the moment the result registers are written. Each result register keeps its value until another operation of its own kind finishes.

Top module: `muldiv_unit`

## Requirements
- R1: With op code 2'b00 (signed multiply), `prod_o` becomes the 64-bit two's-complement product of `opa_i` and `opb_i`, both taken as signed.
- R2: With op code 2'b01 (unsigned multiply), `prod_o` becomes the 64-bit product of the operands, both taken as unsigned.
- R3: With op code 2'b11 (unsigned divide) and a nonzero divisor, `quot_o` is floor(opa_i/opb_i) and `rem_o` is opa_i minus quotient times divisor.
- R4: With op code 2'b10 (signed divide) and a nonzero divisor, the quotient rounds toward zero and the remainder carries the sign of the dividend. The case -2^31 / -1 gives a quotient of -2^31 and a remainder of 0.
- R5: A zero divisor, signed or unsigned, gives `quot_o` = 32'hFFFFFFFF and `rem_o` equal to the dividend.
- R6: After a multiply start is sampled, `busy_o` is high for exactly 32 cycles. `done_o` is high in the cycle after the last busy cycle, and the product is valid in that cycle.
- R7: After a divide start is sampled, `busy_o` is high for exactly 33 cycles. `done_o` and valid results follow in the next cycle.
- R8: A start pulse while `busy_o` is high has no effect on the running operation, its latency or its results.
- R9: `done_o` is high for one cycle per operation. `prod_o` changes only when a multiply completes, and `quot_o`/`rem_o` change only when a divide completes.
- R10: While and just after a synchronous reset, `busy_o`, `done_o`, `prod_o`, `quot_o` and `rem_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle pulse when results are written |
| prod_o | output | 64 | Product of the last multiply |
| quot_o | output | 32 | Quotient of the last divide |
| rem_o | output | 32 | Remainder of the last divide |

## Verification
Random operands drawn from a seeded generator exercise each op code. Every sign combination for the operands then shows whether Booth recoding and sign correction handle negative inputs. Directed operands fill the gaps that random values almost never reach:
- zero, one, all ones, and the most negative and most positive values, which expose carry loss in the multiply accumulator;
- the divide overflow case and a zero divisor, which separate the special-case path from ordinary sign correction.

Mixed sequences of multiplies and divides show whether each result register holds its value. Start pulses injected mid-run, carrying a different op code, show whether a busy request can hijack the operation or change its latency.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_SMUL = 2'b00,
    OP_UMUL = 2'b01,
    OP_SDIV = 2'b10,
    OP_UDIV = 2'b11
  } md_op_e;

  function automatic logic op_is_div(md_op_e o);
    return o[1];
  endfunction

  function automatic logic op_is_signed(md_op_e o);
    return ~o[0];
  endfunction
endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  md_op_e op_i,
  output logic   busy_o,
  output logic   done_o,
  output md_op_e op_o,
  output logic   load_o,
  output logic   step_o,
  output logic   last_o
);
  localparam int MUL_CYC = W;
  localparam int DIV_CYC = W + 1;
  localparam int CW      = $clog2(DIV_CYC + 1);

  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;
  md_op_e        op_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign op_o   = op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_SMUL;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        op_q   <= op_i;
        cnt_q  <= op_is_div(op_i) ? CW'(DIV_CYC - 1) : CW'(MUL_CYC - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // Independent run-length counter for the latency check
  logic [CW-1:0] run_len_q;
  always_ff @(posedge clk) begin
    if (rst)         run_len_q <= '0;
    else if (load_o) run_len_q <= '0;
    else if (busy_q) run_len_q <= run_len_q + 1'b1;
  end

  // R6 R7
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (run_len_q == (op_is_div(op_q) ? CW'(DIV_CYC) : CW'(MUL_CYC))));

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |=> busy_q);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_q) |=> $stable(op_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));
endmodule

// File: rtl/md_mul.sv
module md_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           last_i,
  input  logic           signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int AW = W + 2;

  logic [AW-1:0]  acc_q, mcand_q, sum, acc_n;
  logic [W-1:0]   mq_q, mq_n;
  logic           qm1_q, qm1_n, sgn_q;
  logic [2*W-1:0] prod_q;

  // One iteration: Booth recoding for signed, shift-add for unsigned
  always_comb begin
    if (sgn_q) begin
      unique case ({mq_q[0], qm1_q})
        2'b01:   sum = acc_q + mcand_q;
        2'b10:   sum = acc_q - mcand_q;
        default: sum = acc_q;
      endcase
      acc_n = {sum[AW-1], sum[AW-1:1]};
    end else begin
      sum   = mq_q[0] ? (acc_q + mcand_q) : acc_q;
      acc_n = {1'b0, sum[AW-1:1]};
    end
    mq_n  = {sum[0], mq_q[W-1:1]};
    qm1_n = mq_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mq_q    <= '0;
      qm1_q   <= 1'b0;
      sgn_q   <= 1'b0;
      prod_q  <= '0;
    end else if (load_i) begin
      acc_q   <= '0;
      mq_q    <= b_i;
      qm1_q   <= 1'b0;
      sgn_q   <= signed_i;
      mcand_q <= signed_i ? {{2{a_i[W-1]}}, a_i} : {2'b00, a_i};
    end else if (step_i) begin
      acc_q <= acc_n;
      mq_q  <= mq_n;
      qm1_q <= qm1_n;
      if (last_i) prod_q <= {acc_n[W-1:0], mq_n};
    end
  end

  assign prod_o = prod_q;

  // R2
  unsigned_acc_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !sgn_q) |-> !acc_q[AW-1]);
endmodule

// File: rtl/md_div.sv
module md_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         last_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  logic [W:0]   rem_q;
  logic [W-1:0] q_q, dvs_q, dvd_q;
  logic         neg_q_q, neg_r_q, dz_q;
  logic [W-1:0] quot_q, remr_q;
  logic [W-1:0] mag_a, mag_b;
  logic [W:0]   shifted;
  logic [W+1:0] trial;

  assign mag_a = (signed_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
  assign mag_b = (signed_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;

  // One restoring iteration
  assign shifted = {rem_q[W-1:0], q_q[W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, dvs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      q_q     <= '0;
      dvs_q   <= '0;
      dvd_q   <= '0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      dz_q    <= 1'b0;
      quot_q  <= '0;
      remr_q  <= '0;
    end else if (load_i) begin
      rem_q   <= '0;
      q_q     <= mag_a;
      dvs_q   <= mag_b;
      dvd_q   <= a_i;
      neg_q_q <= signed_i & (a_i[W-1] ^ b_i[W-1]);
      neg_r_q <= signed_i & a_i[W-1];
      dz_q    <= (b_i == '0);
    end else if (step_i && !last_i) begin
      if (trial[W+1]) begin
        rem_q <= shifted;
        q_q   <= {q_q[W-2:0], 1'b0};
      end else begin
        rem_q <= trial[W:0];
        q_q   <= {q_q[W-2:0], 1'b1};
      end
    end else if (last_i) begin
      if (dz_q) begin
        quot_q <= '1;
        remr_q <= dvd_q;
      end else begin
        quot_q <= neg_q_q ? (~q_q + 1'b1) : q_q;
        remr_q <= neg_r_q ? (~rem_q[W-1:0] + 1'b1) : rem_q[W-1:0];
      end
    end
  end

  assign quot_o = quot_q;
  assign rem_o  = remr_q;

  // R3
  partial_rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !last_i && !dz_q) |=> (rem_q < {1'b0, dvs_q}));

  // R5
  div_zero_result_chk: assert property (@(posedge clk) disable iff (rst)
    (last_i && dz_q) |=> ((quot_q == '1) && (remr_q == $past(dvd_q))));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [1:0]     op_i,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] prod_o,
  output logic [W-1:0]   quot_o,
  output logic [W-1:0]   rem_o
);
  md_op_e op_in, op_run;
  logic   load, step, last;
  logic   is_div_in, is_div_run;

  assign op_in      = md_op_e'(op_i);
  assign is_div_in  = op_is_div(op_in);
  assign is_div_run = op_is_div(op_run);

  md_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_in),
    .busy_o(busy_o), .done_o(done_o), .op_o(op_run),
    .load_o(load), .step_o(step), .last_o(last)
  );

  md_mul #(.W(W)) u_mul (
    .clk(clk), .rst(rst),
    .load_i(load & ~is_div_in),
    .step_i(step & ~is_div_run),
    .last_i(last & ~is_div_run),
    .signed_i(op_is_signed(op_in)),
    .a_i(opa_i), .b_i(opb_i),
    .prod_o(prod_o)
  );

  md_div #(.W(W)) u_div (
    .clk(clk), .rst(rst),
    .load_i(load & is_div_in),
    .step_i(step & is_div_run),
    .last_i(last & is_div_run),
    .signed_i(op_is_signed(op_in)),
    .a_i(opa_i), .b_i(opb_i),
    .quot_o(quot_o), .rem_o(rem_o)
  );

  // R9
  prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(prod_o));

  // R9
  divres_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(quot_o) && $stable(rem_o)));
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        busy_o, done_o;
  logic [63:0] prod_o;
  logic [31:0] quot_o, rem_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_prod = '0;
  logic [31:0] exp_quot = '0, exp_rem = '0;

  always #4 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .prod_o(prod_o), .quot_o(quot_o), .rem_o(rem_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_mul(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sa, sb;
    if (op == 2'b00) begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      return sa * sb;
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  function automatic logic [63:0] model_div(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic signed [31:0] sa, sb;
    if (b == 32'd0) return {32'hFFFFFFFF, a};
    if (op == 2'b11) return {a / b, a % b};
    if (a == 32'h80000000 && b == 32'hFFFFFFFF) return {32'h80000000, 32'd0};
    sa = a;
    sb = b;
    return {32'(sa / sb), 32'(sa % sb)};
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input bit inject);
    int cycles;
    int lat;
    string tag;
    logic [63:0] r;
    lat = op[1] ? 33 : 32;
    tag = op[1] ? "R7" : "R6";
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    opa_i = $urandom; opb_i = $urandom;
    cycles = 0;
    while (busy_o === 1'b1 && cycles < 100) begin
      cycles++;
      if (inject && cycles == 5) begin
        start_i = 1'b1; op_i = ~op; opa_i = ~a; opb_i = a;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(cycles == lat, inject ? "R8 latency" : tag, 64'(cycles), 64'(lat));
    check(done_o === 1'b1, "R9 done", 64'(done_o), 64'd1);
    if (!op[1]) begin
      exp_prod = model_mul(op, a, b);
      check(prod_o === exp_prod, op == 2'b00 ? "R1" : "R2", prod_o, exp_prod);
      check({quot_o, rem_o} === {exp_quot, exp_rem}, "R9 div hold", {quot_o, rem_o}, {exp_quot, exp_rem});
    end else begin
      r = model_div(op, a, b);
      exp_quot = r[63:32];
      exp_rem  = r[31:0];
      if (b == 0)             tag = "R5";
      else if (op == 2'b10)   tag = "R4";
      else                    tag = "R3";
      check({quot_o, rem_o} === r, tag, {quot_o, rem_o}, r);
      check(prod_o === exp_prod, "R9 prod hold", prod_o, exp_prod);
    end
    @(negedge clk);
    check(done_o === 1'b0, "R9 pulse", 64'(done_o), 64'd0);
  endtask

  function automatic logic [31:0] pick();
    int unsigned k;
    k = $urandom % 10;
    case (k)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'hFFFFFFFF;
      3: return 32'h80000000;
      4: return 32'h7FFFFFFF;
      5: return $urandom % 16;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10
    check({busy_o, done_o} === 2'b00, "R10 flags", 64'({busy_o, done_o}), 64'd0);
    check(prod_o === 64'd0, "R10 prod", prod_o, 64'd0);
    check({quot_o, rem_o} === 64'd0, "R10 div", {quot_o, rem_o}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o === 1'b0, "R10 idle", 64'(busy_o), 64'd0);

    // Directed corners: R1 R2 R3 R4 R5
    run_op(2'b00, 32'h80000000, 32'h80000000, 0);
    run_op(2'b00, 32'hFFFFFFFF, 32'h7FFFFFFF, 0);
    run_op(2'b00, 32'h80000000, 32'h7FFFFFFF, 0);
    run_op(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    run_op(2'b01, 32'd0, 32'h12345678, 0);
    run_op(2'b11, 32'hFFFFFFFF, 32'd7, 0);
    run_op(2'b11, 32'd5, 32'd9, 0);
    run_op(2'b10, 32'h80000000, 32'hFFFFFFFF, 0);
    run_op(2'b10, -32'sd7, 32'd2, 0);
    run_op(2'b10, 32'd7, -32'sd2, 0);
    run_op(2'b10, -32'sd7, -32'sd2, 0);
    run_op(2'b10, -32'sd9, 32'd0, 0);
    run_op(2'b11, 32'hDEADBEEF, 32'd0, 0);
    // R8: start pulses during a run
    run_op(2'b00, 32'h00001234, 32'hFFFF0000, 1);
    run_op(2'b11, 32'h00ABCDEF, 32'd1000, 1);
    run_op(2'b10, 32'hFFFF0001, 32'd3, 1);
    run_op(2'b01, 32'hCAFEF00D, 32'h0000FFFF, 1);

    // Random mix
    for (int i = 0; i < 160; i++) begin
      run_op(2'($urandom), pick(), pick(), (i % 17) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule